// File: doc/BRIEF.md
# Load/Store-Multiple Micro-Op Sequencer

This block takes one block-transfer instruction and turns it into an ordered stream of simple micro-operation descriptors. The instruction arrives as a 16-bit register mask, a base register index and the flags for direction, load or store, base update, user mode and condition. The block then emits one descriptor per cycle over a valid/ready handshake. Each descriptor carries an operation kind, up to two register indices, the register used for the address, a byte offset and the control flags that the later pipeline needs.

The sequencer does not touch memory or the register file. Its only job is the order and content of the descriptors. That covers where the base is saved to a temporary, which loads are fused into pairs, where the base update goes, and how a load of the program counter (index 15) is marked. A decode stage feeds it one instruction at a time. The issue stage drains the descriptors and uses the first and last markers to bracket the instruction.

Top module: `lsm_seq`

## Requirements
- R1: `in_ready` is high exactly when no instruction is in progress. An instruction accepted on a clock edge presents its first descriptor, with `out_first`=1, from the following cycle. Requests made while busy are ignored.
- R2: One memory transfer happens per set bit of `in_list`, so the number of transfers is its population count. Registers are visited from index 0 upward, and clear bits are skipped.
- R3: A base-copy descriptor comes first, before any memory descriptor, in two cases: a load whose mask contains the base, or an empty mask. It has kind 0, `out_ra`=16 (temporary), `out_rb`=`out_addr_reg`=base and offset 0. When it is present, memory descriptors use `out_addr_reg`=16. Otherwise they use the base.
- R4: On a load with two or more transfers left, the next two registers are fused into one descriptor of kind 2, with the lower index in `out_ra` and the higher in `out_rb`. Single loads have kind 1 and stores have kind 3, each with the register in `out_ra` and `out_rb`=0.
- R5: `out_offset` is the byte offset of `out_ra`'s transfer. Going up, the first offset is 0. Going down, it is 4×count−4. It then moves by 4 per register consumed (8 for a pair), upward or downward to match the direction. `out_up` repeats the direction on every descriptor.
- R6: With writeback and a nonzero count, a base-update descriptor follows the transfers. It has kind 4 (add) when going up or kind 5 (subtract) when going down, with `out_ra`=`out_rb`=`out_addr_reg`=base and offset 4×count.
- R7: A load of register 15 without writeback marks its descriptor as control and indirect. It is also marked conditional when `in_always` is 0, or unconditional when `in_always` is 1. No other memory descriptor has these flags.
- R8: In user mode, a mask without register 15 sets `out_user_bank` on every memory descriptor. A mask with register 15 sets `out_exc_ret` on the descriptor that loads register 15.
- R9: A load of register 15 with writeback targets temporary 17 instead. The sequence then closes with a return-move descriptor: kind 6, `out_ra`=15, `out_rb`=17, flagged control, indirect and return, and conditional or unconditional as in R7.
- R10: Only the first descriptor has `out_first`, and only the last has `out_last`. Every descriptor before the last has `out_dcommit`=1, and the last has it 0. After the last descriptor is taken, `out_valid` drops.
- R11: While `out_ready` is low, the presented descriptor stays unchanged. No descriptor is lost, repeated or reordered.
- R12: `out_macro_ctrl`, sampled with the last descriptor, is 1 exactly when any descriptor of the instruction was marked control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, instruction accepted |
| in_list | input | 16 | Register mask |
| in_base | input | 4 | Base register index |
| in_load | input | 1 | 1 = load, 0 = store |
| in_up | input | 1 | 1 = ascending addresses |
| in_wback | input | 1 | Update the base afterwards |
| in_user | input | 1 | User-mode transfer |
| in_always | input | 1 | Condition is always-true |
| out_valid | output | 1 | Descriptor valid |
| out_ready | input | 1 | Descriptor taken |
| out_kind | output | 3 | Operation kind (0 copy, 1 load, 2 pair, 3 store, 4 add, 5 sub, 6 return move) |
| out_ra | output | 5 | First register index (16, 17 = temporaries) |
| out_rb | output | 5 | Second register index |
| out_addr_reg | output | 5 | Address register |
| out_offset | output | 7 | Byte offset |
| out_up | output | 1 | Direction |
| out_first | output | 1 | First descriptor |
| out_last | output | 1 | Last descriptor |
| out_dcommit | output | 1 | Delayed commit |
| out_ctrl | output | 1 | Control flow |
| out_indirect | output | 1 | Indirect control |
| out_cond | output | 1 | Conditional control |
| out_uncond | output | 1 | Unconditional control |
| out_return | output | 1 | Return |
| out_user_bank | output | 1 | Use user-bank registers |
| out_exc_ret | output | 1 | Exception return load |
| out_macro_ctrl | output | 1 | Instruction contains control flow |

## Verification
The bench targets several corner cases, and each one has a typical failure:
- Empty mask: a design that got it wrong would emit a base update or nothing at all, where a lone base copy is expected.
- Load whose mask holds the base: a wrong design would address through the clobbered base instead of temporary 16.
- Odd load counts: a wrong design would fuse past the end of the mask instead of leaving a trailing single load.
- Full 16-register load with writeback: a wrong design would wrap the 64-byte update offset or lose the closing return move.
- Downward offsets: these are compared per pair, where an off-by-one step shows up at once.
- Replay with a stalling consumer and intrusive requests while busy: this exposes a sequencer that advances without a handshake or accepts a second instruction mid-stream.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [2:0] {
        K_COPY   = 3'd0,
        K_LOAD   = 3'd1,
        K_PAIR   = 3'd2,
        K_STORE  = 3'd3,
        K_ADD    = 3'd4,
        K_SUB    = 3'd5,
        K_RETMOV = 3'd6
    } uop_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_COPY = 3'd1,
        PH_MEM  = 3'd2,
        PH_ADJ  = 3'd3,
        PH_RET  = 3'd4
    } seq_phase_e;

endpackage

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
    parameter int N  = 16,
    parameter int BW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [BW-1:0] idx,
    output logic          hit
);
    always_comb begin
        idx = '0;
        hit = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = BW'(i);
                hit = 1'b1;
            end
        end
    end

    // R2
    always_comb begin
        if (hit) begin
            low_sel_set_chk: assert (vec[idx]);
        end
    end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
    import lsm_pkg::*;
#(
    parameter int REGS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [REGS-1:0]              in_list,
    input  logic [$clog2(REGS)-1:0]      in_base,
    input  logic                         in_load,
    input  logic                         in_up,
    input  logic                         in_wback,
    input  logic                         in_user,
    input  logic                         in_always,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [2:0]                   out_kind,
    output logic [$clog2(REGS):0]        out_ra,
    output logic [$clog2(REGS):0]        out_rb,
    output logic [$clog2(REGS):0]        out_addr_reg,
    output logic [$clog2(4*REGS):0]      out_offset,
    output logic                         out_up,
    output logic                         out_first,
    output logic                         out_last,
    output logic                         out_dcommit,
    output logic                         out_ctrl,
    output logic                         out_indirect,
    output logic                         out_cond,
    output logic                         out_uncond,
    output logic                         out_return,
    output logic                         out_user_bank,
    output logic                         out_exc_ret,
    output logic                         out_macro_ctrl
);
    localparam int BW = $clog2(REGS);
    localparam int IW = BW + 1;
    localparam int CW = $clog2(REGS + 1);
    localparam int OW = $clog2(4 * REGS) + 1;
    localparam logic [IW-1:0] PC_IX    = IW'(REGS - 1);
    localparam logic [IW-1:0] TMP_BASE = IW'(REGS);
    localparam logic [IW-1:0] TMP_PC   = IW'(REGS + 1);
    localparam logic [REGS-1:0] ONE    = {{(REGS-1){1'b0}}, 1'b1};

    typedef struct packed {
        seq_phase_e      phase;
        logic [REGS-1:0] rem;
        logic [CW-1:0]   left;
        logic [CW-1:0]   cnt;
        logic [OW-1:0]   off;
        logic [BW-1:0]   base;
        logic            load;
        logic            up;
        logic            wb;
        logic            always_c;
        logic            pctemp;
        logic            ubank;
        logic            eret;
        logic            via_tmp;
        logic            fresh;
        logic            ctrl_seen;
    } seq_t;

    seq_t st_q, st_d;

    // Population count of the incoming mask
    logic [CW-1:0] in_cnt;
    lsm_popcnt #(.N(REGS), .CW(CW)) u_count (.vec(in_list), .cnt(in_cnt));

    // Two lowest pending registers
    logic [REGS-1:0] scan_b;
    logic [BW-1:0]   pick_a, pick_b;
    logic            hit_a, hit_b;

    lsm_lowbit #(.N(REGS), .BW(BW)) u_pick_lo (.vec(st_q.rem), .idx(pick_a), .hit(hit_a));
    assign scan_b = st_q.rem & ~(ONE << pick_a);
    lsm_lowbit #(.N(REGS), .BW(BW)) u_pick_hi (.vec(scan_b), .idx(pick_b), .hit(hit_b));

    logic [IW-1:0] lo_ix, hi_ix, base_ix;
    assign lo_ix   = {1'b0, pick_a};
    assign hi_ix   = {1'b0, pick_b};
    assign base_ix = {1'b0, st_q.base};

    function automatic logic [IW-1:0] redirect(input logic [IW-1:0] ix, input logic to_tmp);
        return (to_tmp && ix == PC_IX) ? TMP_PC : ix;
    endfunction

    // Descriptor fields
    logic [2:0]    o_kind;
    logic [IW-1:0] o_ra, o_rb, o_addr;
    logic [OW-1:0] o_offset;
    logic          o_ctrl, o_ind, o_cond, o_uncond, o_ret, o_ubank, o_eret;
    logic          pair, pc_hit, copy_need, busy;
    logic [CW-1:0] left_nxt;
    seq_phase_e    nxt;

    assign busy      = (st_q.phase != PH_IDLE);
    assign copy_need = (in_load && in_list[in_base]) || (in_cnt == '0);

    always_comb begin
        st_d     = st_q;
        o_kind   = K_COPY;
        o_ra     = '0;
        o_rb     = '0;
        o_addr   = '0;
        o_offset = '0;
        o_ctrl   = 1'b0;
        o_ind    = 1'b0;
        o_cond   = 1'b0;
        o_uncond = 1'b0;
        o_ret    = 1'b0;
        o_ubank  = 1'b0;
        o_eret   = 1'b0;
        pair     = 1'b0;
        pc_hit   = 1'b0;
        left_nxt = st_q.left;
        nxt      = PH_IDLE;

        if (!busy) begin
            if (in_valid) begin
                st_d.phase     = copy_need ? PH_COPY : PH_MEM;
                st_d.rem       = in_list;
                st_d.left      = in_cnt;
                st_d.cnt       = in_cnt;
                st_d.off       = in_up ? '0 : (OW'({in_cnt, 2'b00}) - OW'(4));
                st_d.base      = in_base;
                st_d.load      = in_load;
                st_d.up        = in_up;
                st_d.wb        = in_wback;
                st_d.always_c  = in_always;
                st_d.pctemp    = in_load && in_wback && in_list[REGS-1];
                st_d.ubank     = in_user && !in_list[REGS-1];
                st_d.eret      = in_user && in_list[REGS-1];
                st_d.via_tmp   = copy_need;
                st_d.fresh     = 1'b1;
                st_d.ctrl_seen = 1'b0;
            end
        end else begin
            case (st_q.phase)
                PH_COPY: begin
                    o_kind = K_COPY;
                    o_ra   = TMP_BASE;
                    o_rb   = base_ix;
                    o_addr = base_ix;
                    nxt    = (st_q.cnt != '0) ? PH_MEM : PH_IDLE;
                end
                PH_MEM: begin
                    pair     = st_q.load && (st_q.left > CW'(1));
                    o_addr   = st_q.via_tmp ? TMP_BASE : base_ix;
                    o_offset = st_q.off;
                    o_ubank  = st_q.ubank;
                    if (pair) begin
                        o_kind = K_PAIR;
                        o_ra   = lo_ix;
                        o_rb   = redirect(hi_ix, st_q.pctemp);
                        pc_hit = (hi_ix == PC_IX);
                    end else begin
                        o_kind = st_q.load ? K_LOAD : K_STORE;
                        o_ra   = st_q.load ? redirect(lo_ix, st_q.pctemp) : lo_ix;
                        pc_hit = st_q.load && (lo_ix == PC_IX);
                    end
                    o_ctrl   = pc_hit && !st_q.wb;
                    o_ind    = o_ctrl;
                    o_cond   = o_ctrl && !st_q.always_c;
                    o_uncond = o_ctrl && st_q.always_c;
                    o_eret   = pc_hit && st_q.eret;
                    left_nxt = st_q.left - (pair ? CW'(2) : CW'(1));
                    nxt      = (left_nxt != '0) ? PH_MEM : (st_q.wb ? PH_ADJ : PH_IDLE);
                end
                PH_ADJ: begin
                    o_kind   = st_q.up ? K_ADD : K_SUB;
                    o_ra     = base_ix;
                    o_rb     = base_ix;
                    o_addr   = base_ix;
                    o_offset = OW'({st_q.cnt, 2'b00});
                    nxt      = st_q.pctemp ? PH_RET : PH_IDLE;
                end
                PH_RET: begin
                    o_kind   = K_RETMOV;
                    o_ra     = PC_IX;
                    o_rb     = TMP_PC;
                    o_ctrl   = 1'b1;
                    o_ind    = 1'b1;
                    o_ret    = 1'b1;
                    o_cond   = !st_q.always_c;
                    o_uncond = st_q.always_c;
                    nxt      = PH_IDLE;
                end
                default: nxt = PH_IDLE;
            endcase

            if (out_ready) begin
                st_d.phase     = nxt;
                st_d.fresh     = 1'b0;
                st_d.ctrl_seen = st_q.ctrl_seen | o_ctrl;
                if (st_q.phase == PH_MEM) begin
                    st_d.left = left_nxt;
                    st_d.rem  = pair ? (scan_b & ~(ONE << pick_b)) : scan_b;
                    st_d.off  = st_q.up ? (st_q.off + (pair ? OW'(8) : OW'(4)))
                                        : (st_q.off - (pair ? OW'(8) : OW'(4)));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready       = !busy;
    assign out_valid      = busy;
    assign out_kind       = o_kind;
    assign out_ra         = o_ra;
    assign out_rb         = o_rb;
    assign out_addr_reg   = o_addr;
    assign out_offset     = o_offset;
    assign out_up         = busy && st_q.up;
    assign out_first      = busy && st_q.fresh;
    assign out_last       = busy && (nxt == PH_IDLE);
    assign out_dcommit    = busy && (nxt != PH_IDLE);
    assign out_ctrl       = o_ctrl;
    assign out_indirect   = o_ind;
    assign out_cond       = o_cond;
    assign out_uncond     = o_uncond;
    assign out_return     = o_ret;
    assign out_user_bank  = o_ubank;
    assign out_exc_ret    = o_eret;
    assign out_macro_ctrl = st_q.ctrl_seen | o_ctrl;

    // R1
    accept_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && out_first);

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_ra)
            && $stable(out_rb) && $stable(out_offset) && $stable(out_last));

    // R10
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid);

    // R9
    retmov_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == K_RETMOV |-> out_last && out_return && out_ctrl);

    // R7
    cond_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0({out_cond, out_uncond}));

    // R3
    copy_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == K_COPY |-> out_first && out_ra == TMP_BASE);

    // R10
    first_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last |=> !out_first);
endmodule

// File: tb/test_lsm_seq.sv
module test_lsm_seq;
    import lsm_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_list = '0;
    logic [3:0]  in_base = '0;
    logic        in_load = 1'b0, in_up = 1'b0, in_wback = 1'b0, in_user = 1'b0, in_always = 1'b0;
    logic        out_valid, out_ready = 1'b1;
    logic [2:0]  out_kind;
    logic [4:0]  out_ra, out_rb, out_addr_reg;
    logic [6:0]  out_offset;
    logic        out_up, out_first, out_last, out_dcommit, out_ctrl, out_indirect;
    logic        out_cond, out_uncond, out_return, out_user_bank, out_exc_ret, out_macro_ctrl;

    always #10 clk = ~clk;

    lsm_seq i_lsm_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_list(in_list), .in_base(in_base), .in_load(in_load), .in_up(in_up),
        .in_wback(in_wback), .in_user(in_user), .in_always(in_always),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_ra(out_ra), .out_rb(out_rb), .out_addr_reg(out_addr_reg),
        .out_offset(out_offset), .out_up(out_up), .out_first(out_first),
        .out_last(out_last), .out_dcommit(out_dcommit), .out_ctrl(out_ctrl),
        .out_indirect(out_indirect), .out_cond(out_cond), .out_uncond(out_uncond),
        .out_return(out_return), .out_user_bank(out_user_bank),
        .out_exc_ret(out_exc_ret), .out_macro_ctrl(out_macro_ctrl)
    );

    typedef struct packed {
        logic [15:0] list;
        logic [3:0]  base;
        logic        ld, up, wb, usr, alw;
        logic [4:0]  nexp;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{16'h000F, 4'd0,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 5'd3,  "R3 "},
        '{16'h0007, 4'd5,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 5'd4,  "R6 "},
        '{16'h8003, 4'd4,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2,  "R7 "},
        '{16'h8001, 4'd2,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 5'd3,  "R9 "},
        '{16'h0000, 4'd3,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 5'd1,  "R3 "},
        '{16'h0410, 4'd1,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 5'd2,  "R8 "},
        '{16'h8000, 4'd0,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 5'd1,  "R8 "},
        '{16'hFFFF, 4'd13, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 5'd11, "R4 "},
        '{16'h0020, 4'd5,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 5'd2,  "R5 "}
    };

    typedef struct packed {
        logic [2:0] kind;
        logic [4:0] ra, rb, ar;
        logic [6:0] off;
        logic       up, c, ind, cnd, unc, ret, ub, er;
    } uop_t;

    uop_t exp_q [0:31];
    int   exp_n;
    logic exp_mc;
    int   errors = 0;
    int   checks = 0;
    bit   done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [2:0] k, input int ra, input int rb, input int ar,
                        input int off, input logic up, input logic c, input logic cnd,
                        input logic unc, input logic ret, input logic ub, input logic er);
        exp_q[exp_n] = '{k, 5'(ra), 5'(rb), 5'(ar), 7'(off), up, c, c, cnd, unc, ret, ub, er};
        exp_n++;
        exp_mc = exp_mc | c;
    endtask

    // Reference sequence built from the requirements
    task automatic build(input vec_t v);
        int regs [16];
        int n = 0;
        int i = 0;
        int off, ar, a, b, ra, rb, step;
        logic copy, pct, ub, er, pcl, c;
        logic [2:0] k;
        for (int r = 0; r < 16; r++) if (v.list[r]) begin regs[n] = r; n++; end
        exp_n = 0;
        exp_mc = 1'b0;
        copy = (v.ld && v.list[v.base]) || (n == 0);
        ar   = copy ? 16 : int'(v.base);
        pct  = v.ld && v.wb && v.list[15];
        ub   = v.usr && !v.list[15];
        er   = v.usr && v.list[15];
        if (copy) push(K_COPY, 16, int'(v.base), int'(v.base), 0, v.up, 0, 0, 0, 0, 0, 0);
        off = v.up ? 0 : 4 * n - 4;
        while (i < n) begin
            if (v.ld && (n - i) >= 2) begin
                a = regs[i]; b = regs[i+1];
                pcl = (b == 15);
                ra = a; rb = (pcl && pct) ? 17 : b;
                k = K_PAIR; step = 8; i += 2;
            end else begin
                a = regs[i];
                pcl = v.ld && (a == 15);
                ra = (pcl && pct) ? 17 : a; rb = 0;
                k = v.ld ? K_LOAD : K_STORE; step = 4; i += 1;
            end
            c = pcl && !v.wb;
            push(k, ra, rb, ar, off, v.up, c, c && !v.alw, c && v.alw, 0, ub, pcl && er);
            off = v.up ? off + step : off - step;
        end
        if (v.wb && n > 0)
            push(v.up ? K_ADD : K_SUB, int'(v.base), int'(v.base), int'(v.base), 4 * n,
                 v.up, 0, 0, 0, 0, 0, 0);
        if (pct) push(K_RETMOV, 15, 17, 0, 0, v.up, 1, !v.alw, v.alw, 1, 0, 0);
    endtask

    task automatic run_vec(input vec_t v, input bit stall);
        int k = 0;
        int cyc = 0;
        uop_t act;
        bit fired_last;
        string tg;
        tg = $sformatf("%s", v.tag);
        build(v);
        chk(exp_n == int'(v.nexp), "R2", "sequence length", 64'(exp_n), 64'(v.nexp));
        @(negedge clk);
        chk(in_ready, "R1", "ready when idle", 64'(in_ready), 64'd1);
        in_list = v.list; in_base = v.base; in_load = v.ld; in_up = v.up;
        in_wback = v.wb; in_user = v.usr; in_always = v.alw; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && out_first, "R1", "first descriptor after accept",
            64'({out_valid, out_first}), 64'b11);
        while (k < exp_n && cyc < 200) begin
            out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            #1;
            fired_last = 1'b0;
            if (!out_valid) begin
                chk(1'b0, "R10", "valid dropped early", 64'(k), 64'(exp_n));
                break;
            end
            if (out_ready) begin
                act = '{out_kind, out_ra, out_rb, out_addr_reg, out_offset, out_up, out_ctrl,
                        out_indirect, out_cond, out_uncond, out_return, out_user_bank, out_exc_ret};
                chk(act == exp_q[k], tg, $sformatf("descriptor %0d (R2 R4 R5)", k),
                    64'(act), 64'(exp_q[k]));
                chk({out_first, out_last, out_dcommit} ==
                    {k == 0, k == exp_n - 1, k != exp_n - 1}, "R10", "first/last/dcommit",
                    64'({out_first, out_last, out_dcommit}),
                    64'({k == 0, k == exp_n - 1, k != exp_n - 1}));
                if (k == exp_n - 1) begin
                    chk(out_macro_ctrl == exp_mc, "R12", "macro control summary",
                        64'(out_macro_ctrl), 64'(exp_mc));
                    fired_last = 1'b1;
                end
                k++;
            end
            // R1: intrusive request while busy must be ignored
            if (stall && !fired_last) begin
                in_list = 16'h5A5A; in_base = 4'd7; in_load = 1'b0; in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        chk(!out_valid, "R11", "no extra descriptor after last", 64'(out_valid), 64'd0);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!out_valid, "R1", "reset valid", 64'(out_valid), 64'd0);
        chk(in_ready, "R1", "reset ready", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && in_ready, "R1", "idle after reset",
            64'({out_valid, in_ready}), 64'b01);
        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < NV; v++) begin
                run_vec(VECS[v], p == 1);
            end
        end
        // R11 directed: hold ready low several cycles on the first descriptor
        begin
            vec_t dv;
            dv = '{16'h0003, 4'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd2, "R11"};
            @(negedge clk);
            in_list = dv.list; in_base = dv.base; in_load = 1'b0; in_up = 1'b0;
            in_wback = 1'b0; in_user = 1'b0; in_always = 1'b1; in_valid = 1'b1;
            out_ready = 1'b0;
            @(negedge clk);
            in_valid = 1'b0;
            repeat (4) @(negedge clk);
            chk(out_valid && out_kind == K_STORE && out_ra == 5'd0 && out_offset == 7'd4,
                "R11", "held store reg0 down offset",
                64'({out_kind, out_ra, out_offset}), 64'({K_STORE, 5'd0, 7'd4}));
            out_ready = 1'b1;
            #1;
            @(negedge clk);
            chk(out_valid && out_ra == 5'd1 && out_offset == 7'd0 && out_last,
                "R11", "second store after stall",
                64'({out_ra, out_offset, out_last}), 64'({5'd1, 7'd0, 1'b1}));
            @(negedge clk);
            chk(!out_valid, "R10", "idle after directed", 64'(out_valid), 64'd0);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule